// File: doc/BRIEF.md
# Ethernet Transmit Request Framer

This block turns a per-packet transmit request from software into an outgoing Ethernet frame. The frame leaves as a byte stream. Software talks to it over a small register bus. For each packet it must first write a command word, then write the frame length, then read the bus status word. Only when those three accesses arrive in that order, and the transmitter is enabled and idle, does the block start a frame.

Once a frame has started, the block pulls the payload one byte per cycle from a byte-wide input and forwards it in order. The payload is the destination and source addresses, the length/type field and the LLC data, all supplied by the host. Two command bits choose, for that frame only, whether short frames are padded with zero bytes up to the 64-byte minimum and whether a 32-bit CRC is appended.

Completion is shown by a done flag in the status word. The same flag can also raise an interrupt, which is masked by an enable bit. Software that leaves the enable clear works in poll mode and watches the done flag instead.

Top module: `eth_tx_framer`

## Requirements

Register map: address 0 holds the command, 1 the length, 2 the status (read only), 3 the buffer configuration and 4 the line control.

- R1: A command write, then a length write, then a status read, in that order, form a valid request. The status read returns bit 8 = 1. The first frame byte appears on `txByte` with `txValid` high from the clock edge that follows the status read's edge.
- R2: An access out of order sends the sequencer back to idle. Out of order means a length write not directly preceded by a command write, or a status read not directly preceded by a length write. The status read then returns bit 8 = 0 and no frame starts.
- R3: The command must be written again for every packet. A length write and status read with no new command write since the last request return bit 8 = 0 and start nothing.
- R4: Reading address 0 returns the last value written to the command register. Such a read does not disturb a request in progress.
- R5: When command bit 12 is set, the frame ends with 4 CRC bytes, sent least significant byte first. The CRC is the standard Ethernet CRC-32 (reflected polynomial 0xEDB88320, start value all ones, final inversion) taken over the data and pad bytes.
- R6: When command bit 13 is set, zero bytes follow the data until the frame, counting the CRC bytes when bit 12 is set, reaches 64 bytes. Frames already that long get no padding. When bit 13 is clear, no pad is added.
- R7: The data bytes leave in the order they were taken from `dataIn`, with no idle cycles inside the frame. `txLast` is high with the final byte only.
- R8: A request is refused (status bit 8 = 0, no frame) while line control bit 9 is clear.
- R9: Status bit 0 reads 1 while a frame is being sent. Status bit 1 is set when the final byte is sent and is cleared by a status read. Both read 0 after reset.
- R10: `txIrq` equals status bit 1 ANDed with buffer configuration bit 8. A change to bit 8 takes effect from the next cycle, even for a frame that is already pending.
- R11: A request completed while a frame is in progress is refused. Command or length writes made during a frame do not change that frame.
- R12: A length of 0, or above 2047, is refused.

## Ports

| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regRe | input | 1 | Register read strobe |
| regAddr | input | 3 | Register address |
| regWdata | input | 16 | Write data |
| regRdata | output | 16 | Read data, valid in the same cycle as the address |
| dataIn | input | 8 | Payload byte, sampled when dataReq is high |
| dataReq | output | 1 | Block takes dataIn at this clock edge |
| txByte | output | 8 | Outgoing frame byte |
| txValid | output | 1 | txByte holds a frame byte |
| txLast | output | 1 | Final byte of the frame |
| txIrq | output | 1 | Transmit-done interrupt |

## Verification

Frames are sent with short lengths that need padding and with lengths that land exactly on the 64-byte boundary, with and without the CRC. This separates a pad target that counts the CRC bytes from one that does not. Random lengths and random command low bits, mixed with these cases, check that only bits 12 and 13 shape the frame and that the CRC bytes come out in the right order. The refusal cases are tried separately against a request that would otherwise be accepted: broken orderings, a missing fresh command, transmit disabled, a bad length and a request made while busy. The interrupt mask is toggled while the done flag is pending, to show that the mask acts at once.

// File: rtl/eth_tx_pkg.sv
`timescale 1ns/1ps
package eth_tx_pkg;
  localparam logic [2:0] ADDR_CMD    = 3'd0;
  localparam logic [2:0] ADDR_LEN    = 3'd1;
  localparam logic [2:0] ADDR_STAT   = 3'd2;
  localparam logic [2:0] ADDR_BUFCFG = 3'd3;
  localparam logic [2:0] ADDR_LINE   = 3'd4;

  localparam int CRC_EN_BIT  = 12;
  localparam int PAD_EN_BIT  = 13;
  localparam int RDY_IEN_BIT = 8;
  localparam int TX_EN_BIT   = 9;

  localparam int ST_BUSY_BIT   = 0;
  localparam int ST_DONE_BIT   = 1;
  localparam int ST_ACCEPT_BIT = 8;

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_CMD, SEQ_LEN} seq_e;
  typedef enum logic [1:0] {PH_IDLE, PH_DATA, PH_PAD, PH_CRC} phase_e;

  typedef struct packed {
    logic       crcInit;
    logic       emitData;
    logic       emitPad;
    logic       emitCrc;
    logic [1:0] crcIdx;
    logic       last;
  } txStrobe_t;
endpackage

// File: rtl/eth_tx_ctrl.sv
`timescale 1ns/1ps
module eth_tx_ctrl
  import eth_tx_pkg::*;
#(
  parameter int REG_W     = 16,
  parameter int LEN_W     = 11,
  parameter int MIN_FRAME = 64,
  parameter int CRC_BYTES = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWe,
  input  logic             regRe,
  input  logic [2:0]       regAddr,
  input  logic [REG_W-1:0] regWdata,
  output logic [REG_W-1:0] regRdata,
  output logic             dataReq,
  output logic             txIrq,
  output txStrobe_t        st
);
  localparam int MAX_LEN = (1 << LEN_W) - 1;
  localparam logic [LEN_W-1:0] PAD_WITH_CRC = LEN_W'(MIN_FRAME - CRC_BYTES);
  localparam logic [LEN_W-1:0] PAD_NO_CRC   = LEN_W'(MIN_FRAME);
  localparam logic [1:0]       CRC_LAST_IDX = 2'(CRC_BYTES - 1);

  logic [REG_W-1:0] cmdReg, lenReg, bufCfg, lineCtl;
  seq_e   seqQ, seqD;
  phase_e phQ, phD;
  logic [LEN_W-1:0] cnt, cntNext, curLen, padTarget;
  logic curCrc, curPad, doneQ;
  logic [1:0] crcIdxQ;
  logic wrCmd, wrLen, rdStat, lenOk, busy, accept;
  logic [REG_W-1:0] statWord;

  assign wrCmd  = regWe && (regAddr == ADDR_CMD);
  assign wrLen  = regWe && (regAddr == ADDR_LEN);
  assign rdStat = regRe && (regAddr == ADDR_STAT);
  assign lenOk  = (lenReg != '0) && (lenReg <= REG_W'(MAX_LEN));
  assign busy   = (phQ != PH_IDLE);
  assign accept = rdStat && (seqQ == SEQ_LEN) && lineCtl[TX_EN_BIT] && !busy && lenOk;

  // request sequencer: command, length, status read
  always_comb begin
    seqD = seqQ;
    if (wrCmd)       seqD = SEQ_CMD;
    else if (wrLen)  seqD = (seqQ == SEQ_CMD) ? SEQ_LEN : SEQ_IDLE;
    else if (rdStat) seqD = SEQ_IDLE;
  end

  assign padTarget = curCrc ? PAD_WITH_CRC : PAD_NO_CRC;
  assign cntNext   = cnt + 1'b1;

  // frame phase control and strobes to the datapath
  always_comb begin
    phD        = phQ;
    st         = '0;
    st.crcIdx  = crcIdxQ;
    st.crcInit = accept;
    case (phQ)
      PH_IDLE: if (accept) phD = PH_DATA;
      PH_DATA: begin
        st.emitData = 1'b1;
        if (cntNext == curLen) begin
          if (curPad && (cntNext < padTarget)) phD = PH_PAD;
          else if (curCrc)                     phD = PH_CRC;
          else begin
            phD     = PH_IDLE;
            st.last = 1'b1;
          end
        end
      end
      PH_PAD: begin
        st.emitPad = 1'b1;
        if (cntNext == padTarget) begin
          if (curCrc) phD = PH_CRC;
          else begin
            phD     = PH_IDLE;
            st.last = 1'b1;
          end
        end
      end
      PH_CRC: begin
        st.emitCrc = 1'b1;
        if (crcIdxQ == CRC_LAST_IDX) begin
          phD     = PH_IDLE;
          st.last = 1'b1;
        end
      end
      default: phD = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdReg  <= '0;
      lenReg  <= '0;
      bufCfg  <= '0;
      lineCtl <= '0;
      seqQ    <= SEQ_IDLE;
      phQ     <= PH_IDLE;
      cnt     <= '0;
      curLen  <= '0;
      curCrc  <= 1'b0;
      curPad  <= 1'b0;
      crcIdxQ <= '0;
      doneQ   <= 1'b0;
    end else begin
      if (wrCmd) cmdReg <= regWdata;
      if (wrLen) lenReg <= regWdata;
      if (regWe && (regAddr == ADDR_BUFCFG)) bufCfg  <= regWdata;
      if (regWe && (regAddr == ADDR_LINE))   lineCtl <= regWdata;
      seqQ <= seqD;
      phQ  <= phD;
      if (accept) begin
        cnt    <= '0;
        curLen <= lenReg[LEN_W-1:0];
        curCrc <= cmdReg[CRC_EN_BIT];
        curPad <= cmdReg[PAD_EN_BIT];
      end else if (st.emitData || st.emitPad) begin
        cnt <= cntNext;
      end
      if (accept)          crcIdxQ <= '0;
      else if (st.emitCrc) crcIdxQ <= crcIdxQ + 1'b1;
      if (st.last)         doneQ <= 1'b1;
      else if (rdStat)     doneQ <= 1'b0;
    end
  end

  always_comb begin
    statWord                = '0;
    statWord[ST_ACCEPT_BIT] = accept;
    statWord[ST_DONE_BIT]   = doneQ;
    statWord[ST_BUSY_BIT]   = busy;
  end

  always_comb begin
    case (regAddr)
      ADDR_CMD:    regRdata = cmdReg;
      ADDR_LEN:    regRdata = lenReg;
      ADDR_STAT:   regRdata = statWord;
      ADDR_BUFCFG: regRdata = bufCfg;
      ADDR_LINE:   regRdata = lineCtl;
      default:     regRdata = '0;
    endcase
  end

  assign dataReq = (phQ == PH_DATA);
  assign txIrq   = doneQ & bufCfg[RDY_IEN_BIT];

  logic [LEN_W:0] frameTot;
  assign frameTot = (phQ == PH_CRC) ? ({1'b0, cnt} + (LEN_W+1)'(CRC_BYTES))
                                    : ({1'b0, cnt} + 1'b1);

  // R1: a frame only begins after a status read that closed a length step
  a_r1_start_after_seq: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(rdStat && (seqQ == SEQ_LEN)));
  // R8: a frame only begins while transmit is enabled
  a_r8_tx_enabled: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(lineCtl[TX_EN_BIT]));
  // R6: a padded frame never ends below the minimum size
  a_r6_min_size: assert property (@(posedge clk) disable iff (!rstN)
    (st.last && curPad) |-> (frameTot >= (LEN_W+1)'(MIN_FRAME)));
  // R9: a status read without a new completion leaves done clear
  a_r9_done_clear: assert property (@(posedge clk) disable iff (!rstN)
    (rdStat && !st.last) |=> !doneQ);
  // R11: the frame settings hold for the whole frame
  a_r11_settings_held: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> ($stable(curLen) && $stable(curCrc) && $stable(curPad)));
endmodule

// File: rtl/eth_tx_dp.sv
`timescale 1ns/1ps
module eth_tx_dp
  import eth_tx_pkg::*;
#(
  parameter int          BYTE_W   = 8,
  parameter int          CRC_W    = 32,
  parameter logic [31:0] CRC_POLY = 32'h04C11DB7
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         st,
  input  logic [BYTE_W-1:0] dataIn,
  output logic [BYTE_W-1:0] txByte,
  output logic              txValid,
  output logic              txLast
);
  function automatic logic [CRC_W-1:0] bitRev(input logic [CRC_W-1:0] v);
    logic [CRC_W-1:0] r;
    for (int i = 0; i < CRC_W; i++) r[i] = v[CRC_W-1-i];
    return r;
  endfunction

  localparam logic [CRC_W-1:0] POLY_REF = bitRev(CRC_POLY[CRC_W-1:0]);

  function automatic logic [CRC_W-1:0] crcStep(input logic [CRC_W-1:0] c,
                                               input logic [BYTE_W-1:0] d);
    logic [CRC_W-1:0] r;
    r = c ^ {{(CRC_W-BYTE_W){1'b0}}, d};
    for (int k = 0; k < BYTE_W; k++)
      r = r[0] ? ((r >> 1) ^ POLY_REF) : (r >> 1);
    return r;
  endfunction

  logic [CRC_W-1:0]  crcReg, crcOut;
  logic [BYTE_W-1:0] nextByte;

  assign crcOut = ~crcReg;

  always_comb begin
    if (st.emitData)     nextByte = dataIn;
    else if (st.emitCrc) nextByte = crcOut[{st.crcIdx, 3'b000} +: BYTE_W];
    else                 nextByte = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      crcReg  <= '1;
      txByte  <= '0;
      txValid <= 1'b0;
      txLast  <= 1'b0;
    end else begin
      if (st.crcInit)       crcReg <= '1;
      else if (st.emitData) crcReg <= crcStep(crcReg, dataIn);
      else if (st.emitPad)  crcReg <= crcStep(crcReg, '0);
      txByte  <= nextByte;
      txValid <= st.emitData | st.emitPad | st.emitCrc;
      txLast  <= st.last;
    end
  end

  // R5: the CRC register is frozen while its bytes are sent
  a_r5_crc_frozen: assert property (@(posedge clk) disable iff (!rstN)
    st.emitCrc |=> $stable(crcReg));
  // R7: the last flag only appears on a valid byte
  a_r7_last_valid: assert property (@(posedge clk) disable iff (!rstN)
    txLast |-> txValid);
  // R6: pad bytes are zero
  a_r6_pad_zero: assert property (@(posedge clk) disable iff (!rstN)
    st.emitPad |=> (txByte == '0));
endmodule

// File: rtl/eth_tx_framer.sv
`timescale 1ns/1ps
module eth_tx_framer
  import eth_tx_pkg::*;
#(
  parameter int REG_W     = 16,
  parameter int LEN_W     = 11,
  parameter int MIN_FRAME = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWe,
  input  logic             regRe,
  input  logic [2:0]       regAddr,
  input  logic [REG_W-1:0] regWdata,
  output logic [REG_W-1:0] regRdata,
  input  logic [7:0]       dataIn,
  output logic             dataReq,
  output logic [7:0]       txByte,
  output logic             txValid,
  output logic             txLast,
  output logic             txIrq
);
  localparam int CRC_W     = 32;
  localparam int CRC_BYTES = CRC_W / 8;

  txStrobe_t st;

  eth_tx_ctrl #(
    .REG_W(REG_W), .LEN_W(LEN_W), .MIN_FRAME(MIN_FRAME), .CRC_BYTES(CRC_BYTES)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regRe(regRe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .dataReq(dataReq),
    .txIrq(txIrq), .st(st)
  );

  eth_tx_dp #(
    .BYTE_W(8), .CRC_W(CRC_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .st(st), .dataIn(dataIn),
    .txByte(txByte), .txValid(txValid), .txLast(txLast)
  );
endmodule

// File: tb/sim_eth_tx_framer.sv
`timescale 1ns/1ps
module sim_eth_tx_framer;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWe = 1'b0, regRe = 1'b0;
  logic [2:0] regAddr = '0;
  logic [15:0] regWdata = '0;
  logic [15:0] regRdata;
  logic [7:0] dataIn;
  logic dataReq, txValid, txLast, txIrq;
  logic [7:0] txByte;

  always #2.5 clk = ~clk;

  eth_tx_framer u0 (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regRe(regRe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .dataIn(dataIn), .dataReq(dataReq),
    .txByte(txByte), .txValid(txValid), .txLast(txLast), .txIrq(txIrq)
  );

  logic [7:0] frameMem [0:2047];
  logic [7:0] expMem   [0:4095];
  logic [7:0] capMem   [0:4095];
  logic clrBench = 1'b0;
  logic [10:0] rdIdx;
  int capCnt = 0, firstCyc = 0, lastCyc = 0, cycCnt = 0;
  bit capDone = 0;
  int nChecks = 0, nErrors = 0;
  bit finished = 0;
  bit ienNow = 0;

  assign dataIn = frameMem[rdIdx];

  always @(posedge clk) begin
    if (clrBench)     rdIdx <= '0;
    else if (dataReq) rdIdx <= rdIdx + 1'b1;
  end

  always @(negedge clk) begin
    cycCnt++;
    if (clrBench) begin
      capCnt = 0;
      capDone = 0;
    end else if (txValid) begin
      capMem[capCnt] = txByte;
      if (capCnt == 0) firstCyc = cycCnt;
      capCnt++;
      if (txLast) begin
        capDone = 1;
        lastCyc = cycCnt;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [2:0] a, input logic [15:0] d);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(posedge clk); #1;
    regWe = 1'b0;
  endtask

  task automatic busRead(input logic [2:0] a, output logic [15:0] d);
    regRe = 1'b1; regAddr = a;
    #1 d = regRdata;
    @(posedge clk); #1;
    regRe = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic clearCapture();
    clrBench = 1'b1;
    @(posedge clk); #1;
    clrBench = 1'b0;
  endtask

  function automatic logic [31:0] benchCrc(input int n);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++) begin
      c ^= {24'h0, expMem[i]};
      for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return ~c;
  endfunction

  // sends one packet, interfere: make a second request while busy
  task automatic runPacket(input int len, input bit crcOn, input bit padOn,
                           input bit interfere, input bit finalRead);
    logic [15:0] cmdVal, rd;
    int padEnd, total, guard, bad;
    logic [31:0] c;
    for (int i = 0; i < len; i++) frameMem[i] = 8'($urandom);
    for (int i = 0; i < len; i++) expMem[i] = frameMem[i];
    padEnd = len;
    if (padOn) begin
      int tgt = crcOn ? 60 : 64;
      while (padEnd < tgt) begin expMem[padEnd] = 8'h00; padEnd++; end
    end
    total = padEnd;
    if (crcOn) begin
      c = benchCrc(padEnd);
      for (int k = 0; k < 4; k++) expMem[padEnd + k] = c[8*k +: 8];
      total = padEnd + 4;
    end
    clearCapture();
    cmdVal = (16'($urandom) & 16'hCFFF) | (16'(crcOn) << 12) | (16'(padOn) << 13);
    busWrite(3'd0, cmdVal);
    busRead(3'd0, rd);
    check(rd == cmdVal, "R4 command readback", rd, cmdVal);
    busWrite(3'd1, 16'(len));
    busRead(3'd2, rd);
    check(rd[8] == 1'b1, "R1 request accepted", rd, 16'h0100);
    if (interfere) begin
      busWrite(3'd0, 16'h0000);
      busWrite(3'd1, 16'd3);
      busRead(3'd2, rd);
      check(rd[8] == 1'b0, "R11 request while busy refused", rd[8], 0);
      check(rd[0] == 1'b1, "R9 busy flag during frame", rd[0], 1);
    end
    guard = 0;
    while (!capDone && guard < 5000) begin @(posedge clk); #1; guard++; end
    check(capCnt == total, "R7 R6 frame byte count", capCnt, total);
    check((lastCyc - firstCyc) == (total - 1), "R7 no gaps in frame",
          lastCyc - firstCyc, total - 1);
    bad = 0;
    for (int i = 0; i < len; i++) if (capMem[i] != expMem[i]) bad++;
    check(bad == 0, "R7 data bytes in order", bad, 0);
    bad = 0;
    for (int i = len; i < padEnd; i++) if (capMem[i] != 8'h00) bad++;
    check(bad == 0, "R6 pad bytes zero", bad, 0);
    if (crcOn) begin
      bad = 0;
      for (int i = padEnd; i < total; i++) if (capMem[i] != expMem[i]) bad++;
      check(bad == 0, "R5 crc bytes", bad, 0);
    end
    check(txIrq == ienNow, "R10 irq follows done and mask", txIrq, ienNow);
    if (finalRead) begin
      busRead(3'd2, rd);
      check(rd[1:0] == 2'b10, "R9 done set, busy clear", rd[1:0], 2);
      busRead(3'd2, rd);
      check(rd[1] == 1'b0, "R9 done cleared by read", rd[1], 0);
    end
  endtask

  // attempt expected to be refused, then confirm no frame was sent
  task automatic expectNoFrame(input string tag);
    idle(30);
    check(capCnt == 0, tag, capCnt, 0);
  endtask

  initial begin
    logic [15:0] rd;
    void'($urandom(32'd1234));
    for (int i = 0; i < 2048; i++) frameMem[i] = 8'h00;
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    idle(1);
    busRead(3'd2, rd);
    check(rd == 16'h0000, "R9 status zero after reset", rd, 0);
    check(txValid == 1'b0 && txIrq == 1'b0, "R9 outputs idle after reset",
          {txValid, txIrq}, 0);

    // R8: transmit disabled
    clearCapture();
    busWrite(3'd0, 16'h3000);
    busWrite(3'd1, 16'd10);
    busRead(3'd2, rd);
    check(rd[8] == 1'b0, "R8 refused while tx disabled", rd[8], 0);
    expectNoFrame("R8 no frame while tx disabled");

    busWrite(3'd4, 16'h0200);
    busWrite(3'd3, 16'h0100);
    ienNow = 1;

    // directed corners around the 64-byte boundary
    runPacket(60, 1, 1, 0, 1);
    runPacket(59, 1, 1, 0, 1);
    runPacket(10, 1, 1, 0, 1);
    runPacket(63, 0, 1, 0, 1);
    runPacket(64, 0, 1, 0, 1);
    runPacket(5, 0, 0, 0, 1);
    runPacket(5, 1, 0, 0, 1);
    runPacket(1, 1, 1, 0, 1);

    // R10: mask acts at once on a pending done
    runPacket(20, 1, 0, 0, 0);
    busWrite(3'd3, 16'h0000);
    check(txIrq == 1'b0, "R10 mask clears irq at once", txIrq, 0);
    busWrite(3'd3, 16'h0100);
    check(txIrq == 1'b1, "R10 unmask raises irq at once", txIrq, 1);
    busRead(3'd2, rd);
    check(rd[1] == 1'b1, "R9 done seen in poll", rd[1], 1);
    check(txIrq == 1'b0, "R10 irq drops after status read", txIrq, 0);

    // R11: second request while busy
    runPacket(100, 1, 0, 1, 1);

    // R3: no fresh command
    clearCapture();
    busWrite(3'd1, 16'd8);
    busRead(3'd2, rd);
    check(rd[8] == 1'b0, "R3 stale command refused", rd[8], 0);
    expectNoFrame("R3 no frame without fresh command");

    // R2: out-of-order orderings
    clearCapture();
    busWrite(3'd0, 16'h1000);
    busRead(3'd2, rd);
    check(rd[8] == 1'b0, "R2 status read after command refused", rd[8], 0);
    busWrite(3'd1, 16'd8);
    busRead(3'd2, rd);
    check(rd[8] == 1'b0, "R2 broken sequence stays idle", rd[8], 0);
    busWrite(3'd0, 16'h1000);
    busWrite(3'd1, 16'd8);
    busWrite(3'd1, 16'd8);
    busRead(3'd2, rd);
    check(rd[8] == 1'b0, "R2 double length write refused", rd[8], 0);
    expectNoFrame("R2 no frame from broken sequences");

    // R12: bad lengths
    clearCapture();
    busWrite(3'd0, 16'h3000);
    busWrite(3'd1, 16'd0);
    busRead(3'd2, rd);
    check(rd[8] == 1'b0, "R12 zero length refused", rd[8], 0);
    busWrite(3'd0, 16'h3000);
    busWrite(3'd1, 16'd3000);
    busRead(3'd2, rd);
    check(rd[8] == 1'b0, "R12 oversize length refused", rd[8], 0);
    expectNoFrame("R12 no frame for bad length");

    // random packets
    for (int p = 0; p < 12; p++) begin
      int len = 1 + int'($urandom % 90);
      runPacket(len, 1'($urandom), 1'($urandom), 0, 1);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nErrors++;
      $display("FAIL watchdog expired before end of run");
      $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
      $finish;
    end
  end
endmodule